// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block is the clocked digital core that decides when the gate of a synchronous-rectifier switch is driven. It does no analog sensing. Outside comparators supply five flags: the drain is above the rearm level, drain-to-source is below the turn-on level, drain-to-source has risen to the turn-off level, the supply is good, and the block is enabled. An active-low override input, `sync_n_i`, lets the converter's controller end a conduction interval at any moment. Two register inputs give the minimum on-time and the minimum off-time as clock-cycle counts.

Each conduction cycle follows the same order. The block waits for the drain to rise above the rearm level, and then holds the gate off for the minimum off-time. After that it arms. When drain-to-source falls below the turn-on level, the gate goes high and the on-time blank starts. While the blank runs, the turn-off flag cannot end the pulse. After the blank, the turn-off flag does end it. The on-time blank also sorts cycles into two kinds. A cycle whose turn-off flag arrives inside the blank marks the block as lightly loaded. The next cycle then runs its sequence with the gate held low. A cycle whose turn-off flag arrives after the blank clears the mark. Two conditions override the sequence: losing supply-good (undervoltage) and dropping enable (sleep). The state and the light-load mark are exported.

Top module: `sr_gate_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `state_o` is 0 (undervoltage), `gate_o` is 0 and `light_load_o` is 0 until synchronized inputs say otherwise.
- R2: Undervoltage has priority over every other condition. A low `supply_ok_i` forces `gate_o` low in the same cycle, with no synchronizer delay. Once it is synchronized, it puts `state_o` at 0 and clears `light_load_o`. When the supply is good but `enable_i` is low after synchronization, `state_o` becomes 1 (sleep), `gate_o` is low and `light_load_o` is cleared.
- R3: State codes are as follows: 0 undervoltage, 1 sleep, 2 wait-for-rearm, 3 armed, 4 on-blank, 5 on, 6 off-blank. With supply and enable both high, states 0 and 1 move to 2. State 2 moves to 6 when the rearm flag is high. State 3 is entered only from state 6 after the off-time has run out.
- R4: In state 3, with SYNC high, the turn-on flag moves the block to state 4 and loads the on-time. `gate_o` goes high unless the light-load mark is set.
- R5: State 4 lasts exactly `ton_cycles_i`+1 cycles, so a value of 0 gives one cycle. The turn-off flag does not end state 4. The block then moves to state 5 with the gate still high.
- R6: In state 5, the turn-off flag moves the block to state 2 and drives `gate_o` low.
- R7: If the turn-off flag is seen in any cycle of state 4, `light_load_o` becomes 1 when that cycle leaves state 5. The following cycle then passes through states 4 and 5 with `gate_o` held low.
- R8: A cycle that leaves state 5 on a turn-off flag that was not seen during state 4 sets `light_load_o` to 0. The cycle after it drives the gate again.
- R9: State 6 lasts exactly `toff_cycles_i`+1 cycles, with `gate_o` low throughout.
- R10: A low `sync_n_i` forces `gate_o` low in the same cycle. Once synchronized, a low SYNC in state 4 or 5 moves the block to state 2 and leaves `light_load_o` unchanged. A low SYNC in state 3 keeps the block in state 3.
- R11: Every comparator, mode and SYNC input passes through `SYNC_STAGES` flops. A change at an input first alters `state_o` after the (`SYNC_STAGES`+1)th rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | Drain above rearm level |
| von_i | input | 1 | Drain-source below turn-on level |
| voff_i | input | 1 | Drain-source at or above turn-off level |
| supply_ok_i | input | 1 | Supply good; low means undervoltage |
| enable_i | input | 1 | Run enable; low means sleep |
| sync_n_i | input | 1 | Active-low forced turn-off |
| ton_cycles_i | input | TIME_W | Minimum on-time in cycles, minus one |
| toff_cycles_i | input | TIME_W | Minimum off-time in cycles, minus one |
| gate_o | output | 1 | Gate command |
| state_o | output | 3 | Sequencer state code |
| light_load_o | output | 1 | Light-load mark |

## Verification
The bench builds the block with `TIME_W` = 6 and `SYNC_STAGES` = 3. The narrow timer makes the largest on-time count, 63, cheap enough to run through in full, which tests the R5 length at its upper end as well as at zero. The three-stage synchronizer checks that the input latency follows the parameter rather than a fixed depth of two. The behavioural model tracks state, light-load mark and gate on every cycle. It does so across light-load entry and exit, SYNC overrides in the armed and conducting states, and undervoltage and sleep arriving mid-sequence.

// File: rtl/sr_pkg.sv
package sr_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_UV    = 3'd0,
      ST_SLEEP = 3'd1,
      ST_WAIT  = 3'd2,
      ST_ARMED = 3'd3,
      ST_ONB   = 3'd4,
      ST_ON    = 3'd5,
      ST_OFFB  = 3'd6
   } sr_state_e;

   localparam int FLAG_REARM = 0;
   localparam int FLAG_VON   = 1;
   localparam int FLAG_VOFF  = 2;
   localparam int FLAG_SUP   = 3;
   localparam int FLAG_EN    = 4;
   localparam int FLAG_SYNCN = 5;
   localparam int FLAG_N     = 6;

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
   parameter int          W       = 6,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sr_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sr_timer.sv
module sr_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] value_i,
   output logic         done_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("sr_timer: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load_i)      cnt <= value_i;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign done_o = (cnt == '0);

   AST_TIMER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load_i) |=> (cnt == '0)); // R9

   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !load_i) |=> (cnt == $past(cnt) - 1'b1)); // R5

endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
   import sr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      s_rearm,
   input  logic      s_von,
   input  logic      s_voff,
   input  logic      s_supply,
   input  logic      s_enable,
   input  logic      s_sync_n,
   input  logic      ton_done,
   input  logic      toff_done,
   output sr_state_e state_o,
   output logic      ton_load_o,
   output logic      toff_load_o,
   output logic      light_load_o,
   output logic      skip_o
);

   sr_state_e st, st_n;
   logic      ll, ll_n;
   logic      early, early_n;
   logic      skip, skip_n;

   always_comb begin
      st_n        = st;
      ll_n        = ll;
      early_n     = early;
      skip_n      = skip;
      ton_load_o  = 1'b0;
      toff_load_o = 1'b0;
      if (!s_supply) begin
         st_n = ST_UV;
         ll_n = 1'b0;
      end else if (!s_enable) begin
         st_n = ST_SLEEP;
         ll_n = 1'b0;
      end else begin
         unique case (st)
            ST_UV, ST_SLEEP: st_n = ST_WAIT;
            ST_WAIT: begin
               if (s_rearm) begin
                  st_n        = ST_OFFB;
                  toff_load_o = 1'b1;
               end
            end
            ST_OFFB: begin
               if (toff_done) st_n = ST_ARMED;
            end
            ST_ARMED: begin
               if (s_sync_n && s_von) begin
                  st_n       = ST_ONB;
                  ton_load_o = 1'b1;
                  early_n    = 1'b0;
                  skip_n     = ll;
               end
            end
            ST_ONB: begin
               if (!s_sync_n) begin
                  st_n = ST_WAIT;
               end else begin
                  early_n = early | s_voff;
                  if (ton_done) st_n = ST_ON;
               end
            end
            ST_ON: begin
               if (!s_sync_n) begin
                  st_n = ST_WAIT;
               end else if (s_voff) begin
                  st_n = ST_WAIT;
                  ll_n = early;
               end
            end
            default: st_n = ST_UV;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_UV;
         ll    <= 1'b0;
         early <= 1'b0;
         skip  <= 1'b0;
      end else begin
         st    <= st_n;
         ll    <= ll_n;
         early <= early_n;
         skip  <= skip_n;
      end
   end

   assign state_o      = st;
   assign light_load_o = ll;
   assign skip_o       = skip;

   AST_UV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !s_supply |=> (st == ST_UV && !ll)); // R2

   AST_ARM_AFTER_OFFB: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ARMED && $past(st) != ST_ARMED) |-> ($past(st) == ST_OFFB && $past(toff_done))); // R3

   AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ONB && !ton_done && s_sync_n && s_supply && s_enable) |=> (st == ST_ONB)); // R5

   AST_SYNC_BLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ARMED && !s_sync_n) |=> (st != ST_ONB)); // R10

   AST_LL_SET_AT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ll) |-> ($past(st) == ST_ON)); // R7

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
   import sr_pkg::*;
#(
   parameter int TIME_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit FAST_FORCE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rearm_i,
   input  logic              von_i,
   input  logic              voff_i,
   input  logic              supply_ok_i,
   input  logic              enable_i,
   input  logic              sync_n_i,
   input  logic [TIME_W-1:0] ton_cycles_i,
   input  logic [TIME_W-1:0] toff_cycles_i,
   output logic              gate_o,
   output logic [STATE_W-1:0] state_o,
   output logic              light_load_o
);

   localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(1) << FLAG_SYNCN;

   generate
      if (TIME_W < 2 || TIME_W > 32) begin : g_bad_time
         $error("sr_gate_seq: TIME_W out of range");
      end
   endgenerate

   logic [FLAG_N-1:0] raw_flags, s_flags;
   sr_state_e         st;
   logic              ton_load, toff_load, ton_done, toff_done;
   logic              skip, gate_int;

   assign raw_flags[FLAG_REARM] = rearm_i;
   assign raw_flags[FLAG_VON]   = von_i;
   assign raw_flags[FLAG_VOFF]  = voff_i;
   assign raw_flags[FLAG_SUP]   = supply_ok_i;
   assign raw_flags[FLAG_EN]    = enable_i;
   assign raw_flags[FLAG_SYNCN] = sync_n_i;

   sr_sync #(.W(FLAG_N), .STAGES(SYNC_STAGES), .RST_VAL(FLAG_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_flags),
      .q_o   (s_flags)
   );

   sr_timer #(.W(TIME_W)) u_ton (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (ton_load),
      .value_i (ton_cycles_i),
      .done_o  (ton_done)
   );

   sr_timer #(.W(TIME_W)) u_toff (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (toff_load),
      .value_i (toff_cycles_i),
      .done_o  (toff_done)
   );

   sr_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .s_rearm      (s_flags[FLAG_REARM]),
      .s_von        (s_flags[FLAG_VON]),
      .s_voff       (s_flags[FLAG_VOFF]),
      .s_supply     (s_flags[FLAG_SUP]),
      .s_enable     (s_flags[FLAG_EN]),
      .s_sync_n     (s_flags[FLAG_SYNCN]),
      .ton_done     (ton_done),
      .toff_done    (toff_done),
      .state_o      (st),
      .ton_load_o   (ton_load),
      .toff_load_o  (toff_load),
      .light_load_o (light_load_o),
      .skip_o       (skip)
   );

   assign gate_int = (st == ST_ONB || st == ST_ON) && !skip;

   generate
      if (FAST_FORCE) begin : g_fast
         assign gate_o = gate_int & sync_n_i & supply_ok_i;
      end else begin : g_slow
         assign gate_o = gate_int;
      end
   endgenerate

   assign state_o = st;

   AST_SKIP_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (skip && st == ST_ONB) |-> !gate_o); // R7

   AST_OFFB_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OFFB || st == ST_ARMED || st == ST_WAIT) |-> !gate_o); // R9

endmodule

// File: tb/sim_sr_gate_seq.sv
module sim_sr_gate_seq;

   localparam int PERIOD = 10;
   localparam int TW     = 6;
   localparam int STG    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rearm = 0, von = 0, voff = 0, sup = 0, en = 0, syncn = 1;
   logic [TW-1:0] ton = 3, toff = 4;
   logic gate;
   logic [2:0] state;
   logic ll;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit cmp_on = 0;
   string phase = "R1";

   always #(PERIOD/2) clk = ~clk;

   sr_gate_seq #(.TIME_W(TW), .SYNC_STAGES(STG)) u0 (
      .clk(clk), .rst_n(rst_n), .rearm_i(rearm), .von_i(von), .voff_i(voff),
      .supply_ok_i(sup), .enable_i(en), .sync_n_i(syncn),
      .ton_cycles_i(ton), .toff_cycles_i(toff),
      .gate_o(gate), .state_o(state), .light_load_o(ll)
   );

   // behavioural reference
   logic [5:0] pq [STG];
   int m_st = 0, m_cnt = 0;
   bit m_ll = 0, m_early = 0, m_skip = 0;

   always @(posedge clk) begin
      logic [5:0] f;
      if (!rst_n) begin
         for (int i = 0; i < STG; i++) pq[i] = 6'b100000;
         m_st = 0; m_cnt = 0; m_ll = 0; m_early = 0; m_skip = 0;
      end else begin
         f = pq[STG-1];
         if (!f[3]) begin m_st = 0; m_ll = 0; end
         else if (!f[4]) begin m_st = 1; m_ll = 0; end
         else begin
            if (m_cnt > 0 && m_st != 6 && m_st != 4) m_cnt = m_cnt;
            case (m_st)
               0, 1: m_st = 2;
               2: if (f[0]) begin m_st = 6; m_cnt = toff; end
               6: if (m_cnt == 0) m_st = 3; else m_cnt--;
               3: if (f[5] && f[1]) begin m_st = 4; m_cnt = ton; m_early = 0; m_skip = m_ll; end
               4: if (!f[5]) m_st = 2;
                  else begin
                     m_early = m_early | f[2];
                     if (m_cnt == 0) m_st = 5; else m_cnt--;
                  end
               5: if (!f[5]) m_st = 2;
                  else if (f[2]) begin m_st = 2; m_ll = m_early; end
               default: m_st = 0;
            endcase
         end
         for (int i = STG-1; i > 0; i--) pq[i] = pq[i-1];
         pq[0] = {syncn, en, sup, voff, von, rearm};
      end
   end

   function automatic bit m_gate();
      return (m_st == 4 || m_st == 5) && !m_skip && syncn && sup;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk(state == 3'(m_st), {phase, " state"}, state, m_st);
         chk(gate == m_gate(), {phase, " gate"}, gate, m_gate());
         chk(ll == m_ll, {phase, " light_load"}, ll, m_ll);
      end
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wait_state(int want, output int n);
      n = 0;
      do begin step(1); n++; end while (state != 3'(want) && n < 200);
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(PERIOD*150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual 1 expected 0");
         finish_run();
      end
   end

   initial begin
      int n;
      step(4);
      phase = "R1"; cmp_on = 1;
      chk(state == 0 && gate == 0 && ll == 0, "R1 reset outputs", state, 0);
      rst_n = 1;
      step(3);
      chk(state == 0, "R1 after release", state, 0);

      phase = "R2"; sup = 1;
      wait_state(1, n);
      chk(state == 1 && gate == 0, "R2 sleep", state, 1);

      phase = "R11"; en = 1; n = 0;
      do begin step(1); n++; end while (state == 1 && n < 20);
      chk(n == STG + 1, "R11 latency", n, STG + 1);
      chk(state == 2, "R3 wait", state, 2);

      phase = "R9"; rearm = 1;
      wait_state(6, n);
      wait_state(3, n);
      chk(n == int'(toff) + 1, "R9 off length", n, int'(toff) + 1);
      chk(state == 3, "R3 armed", state, 3);
      rearm = 0;

      phase = "R7"; von = 1; voff = 1;
      wait_state(4, n);
      chk(gate == 1, "R4 gate on", gate, 1);
      von = 0;
      step(1);
      chk(state == 4 && gate == 1, "R5 blank ignores off", state, 4);
      wait_state(2, n);
      chk(ll == 1, "R7 light set", ll, 1);
      voff = 0;

      rearm = 1; wait_state(3, n); rearm = 0;
      von = 1; wait_state(4, n);
      chk(gate == 0, "R7 pulse suppressed", gate, 0);
      von = 0; step(8);
      chk(state == 5 && gate == 0, "R7 suppressed on", state, 5);
      phase = "R8"; voff = 1; wait_state(2, n);
      chk(ll == 0, "R8 light clear", ll, 0);
      chk(gate == 0, "R6 gate off", gate, 0);
      voff = 0;
      rearm = 1; wait_state(3, n); rearm = 0;
      von = 1; wait_state(4, n);
      chk(gate == 1, "R8 gate resumes", gate, 1);
      von = 0;

      phase = "R10"; wait_state(5, n);
      syncn = 0; #1;
      chk(gate == 0, "R10 immediate force", gate, 0);
      wait_state(2, n);
      chk(state == 2, "R10 ends conduction", state, 2);
      rearm = 1; wait_state(3, n); rearm = 0;
      von = 1; step(8);
      chk(state == 3, "R10 armed held", state, 3);
      syncn = 1; wait_state(4, n);
      chk(gate == 1, "R10 released", gate, 1);
      von = 0;

      phase = "R2"; sup = 0; #1;
      chk(gate == 0, "R2 immediate uv", gate, 0);
      wait_state(0, n);
      chk(state == 0 && ll == 0, "R2 uv state", state, 0);
      sup = 1; wait_state(2, n);

      phase = "R5"; ton = 0; toff = 0;
      rearm = 1; wait_state(6, n); wait_state(3, n);
      chk(n == 1, "R9 zero off", n, 1);
      rearm = 0; von = 1; wait_state(4, n); von = 0;
      step(1);
      chk(state == 5, "R5 zero on", state, 5);
      voff = 1; wait_state(2, n);
      chk(ll == 0, "R8 late off", ll, 0);
      voff = 0;

      ton = 6'd63; toff = 4;
      rearm = 1; wait_state(3, n); rearm = 0;
      von = 1; voff = 1; wait_state(4, n); von = 0;
      wait_state(5, n);
      chk(n == 64, "R5 max on length", n, 64);
      wait_state(2, n);
      chk(ll == 1, "R7 light set max", ll, 1);
      voff = 0;

      phase = "R2"; rearm = 1; wait_state(3, n);
      en = 0; wait_state(1, n);
      chk(state == 1 && ll == 0, "R2 sleep clears light", ll, 0);
      step(3);
      finish_run();
   end

endmodule